// File: doc/BRIEF.md
# Device-Memory Ordered Write Bridge

This block sits between a processor load/store port and a downstream memory bus. Every request carries a 2-bit device mode. The mode decides three things for that request alone: whether the write may be combined with the write before it, whether a read may overtake buffered writes, and whether a write is acknowledged once it is captured or only after the bus reports completion.

Writes that may be acknowledged early go into a small posted-write queue. Reads and strictly acknowledged writes go straight to a single registered issue stage, which is shared with the queue head; a read that is ready to go takes priority over the head. The block keeps a small in-order record of outstanding downstream transactions. This record routes each downstream response to the read return, to the late write acknowledge, or to nowhere.

Top module: `devmem_wbuf`

## Requirements
- R1: After reset, `dn_valid`, `wr_ack` and `rd_valid` are low, and `req_ready` is high for a read offered to the idle block.
- R2: The mode field is encoded as 00 = strict (no merge, no reorder, late ack), 01 = posted (early ack), 10 = relaxed (reorder and early ack), and 11 = gathering (merge, reorder and early ack). In modes 01, 10 and 11 an accepted write raises `wr_ack` for one cycle in the cycle after acceptance, even while the downstream bus is stalled.
- R3: A mode-00 write is accepted only when the posted queue is empty and no other mode-00 write is outstanding. Its `wr_ack` is raised one cycle after the downstream write response, with `wr_ack_err` copying that response's error flag. While it is outstanding, `req_ready` stays low for every request.
- R4: Outside mode 11, every accepted request produces its own downstream transaction. Two reads of the same address give two downstream reads.
- R5: A mode-11 write is merged into the newest queued entry when all of the following hold: it targets the same data word, that entry was also queued in mode 11, and at least two entries are queued. In a merge, bytes whose strobe is set replace the stored bytes and the strobes are ORed. It is still acknowledged as in R2.
- R6: A read in mode 00 or 01 is accepted only when the posted queue is empty, so it reaches the bus after every earlier write.
- R7: A read in mode 10 or 11 overtakes queued writes to other words and takes the issue stage before the queue head. It waits while any queued entry holds its word.
- R8: The queue holds `BUF_DEPTH` writes; with the issue stage full as well, `req_ready` is low for early-ack writes.
- R9: Once `dn_valid` is high, it and the transaction fields hold until `dn_ready`.
- R10: A read result appears on `rd_valid`/`rd_data`/`rd_err` one cycle after its downstream response. Error flags on responses to early-acknowledged writes are dropped (`wr_ack_err` stays low for them).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mode | input | 2 | Device mode (see R2) |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Write data |
| req_strb | input | DW/8 | Write byte strobes |
| wr_ack | output | 1 | Write acknowledge pulse |
| wr_ack_err | output | 1 | Error flag of a late acknowledge |
| rd_valid | output | 1 | Read result pulse |
| rd_data | output | DW | Read data |
| rd_err | output | 1 | Read error flag |
| dn_valid | output | 1 | Downstream transaction valid |
| dn_ready | input | 1 | Downstream accepts transaction |
| dn_write | output | 1 | Downstream direction |
| dn_addr | output | AW | Downstream byte address |
| dn_wdata | output | DW | Downstream write data |
| dn_strb | output | DW/8 | Downstream byte strobes |
| dn_rsp_valid | input | 1 | Downstream response, in issue order |
| dn_rsp_rdata | input | DW | Response read data |
| dn_rsp_err | input | 1 | Response error flag |

## Verification
The assertions assume the downstream side sends a response only while at least one of its transactions is still outstanding, and always in issue order. They also assume request fields stay steady while `req_valid` waits for `req_ready`. The bench's bus model answers each accepted transaction once, through a first-in first-out queue. Its driver sets request fields once per request and holds them until the handshake. Stalls are made only by holding `dn_ready` low.

// File: rtl/dwb_pkg.sv
package dwb_pkg;

   typedef enum logic [1:0] {
      MODE_STRICT  = 2'b00,
      MODE_POSTED  = 2'b01,
      MODE_RELAXED = 2'b10,
      MODE_GATHER  = 2'b11
   } dev_mode_e;

   typedef enum logic [1:0] {
      K_READ   = 2'd0,
      K_POSTED = 2'd1,
      K_LATE   = 2'd2
   } rsp_kind_e;

   function automatic logic mode_early(input logic [1:0] m);
      return m != MODE_STRICT;
   endfunction

   function automatic logic mode_reorder(input logic [1:0] m);
      return m[1];
   endfunction

   function automatic logic mode_gather(input logic [1:0] m);
      return m == MODE_GATHER;
   endfunction

endpackage

// File: rtl/dwb_kind_fifo.sv
module dwb_kind_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_i,
   input  logic [W-1:0] din_i,
   input  logic         pop_i,
   output logic [W-1:0] dout_o,
   output logic         full_o,
   output logic         empty_o
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   initial assert (DEPTH >= 2 && (1 << PW) == DEPTH)
      else $error("dwb_kind_fifo: DEPTH must be a power of two >= 2");

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] rp, wp;
   logic [CW-1:0] cnt;

   assign full_o  = cnt == CW'(DEPTH);
   assign empty_o = cnt == '0;
   assign dout_o  = mem[rp];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rp  <= '0;
         wp  <= '0;
         cnt <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         if (push_i) begin
            mem[wp] <= din_i;
            wp      <= wp + 1'b1;
         end
         if (pop_i) rp <= rp + 1'b1;
         cnt <= cnt + CW'(push_i) - CW'(pop_i);
      end
   end

   // R10: a response must belong to an outstanding transaction
   a_r10_rsp_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> !empty_o);
   a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      full_o |-> !push_i);

endmodule

// File: rtl/dwb_post_buffer.sv
module dwb_post_buffer #(
   parameter int DEPTH    = 4,
   parameter int WAW      = 30,
   parameter int DW       = 32,
   parameter bit MERGE_EN = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push_i,
   input  logic                       merge_i,
   input  logic                       pop_i,
   input  logic [WAW-1:0]             in_waddr,
   input  logic [DW-1:0]              in_data,
   input  logic [DW/8-1:0]            in_strb,
   input  logic                       in_gather,
   output logic [WAW-1:0]             head_waddr,
   output logic [DW-1:0]              head_data,
   output logic [DW/8-1:0]            head_strb,
   output logic [WAW-1:0]             tail_waddr,
   output logic                       tail_gather,
   output logic [$clog2(DEPTH+1)-1:0] count_o,
   output logic                       full_o,
   output logic                       empty_o,
   input  logic [WAW-1:0]             probe_waddr,
   output logic                       probe_hit
);
   localparam int SW = DW / 8;
   localparam int PW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   initial assert (DEPTH >= 2 && (1 << PW) == DEPTH)
      else $error("dwb_post_buffer: DEPTH must be a power of two >= 2");
   initial assert (DW % 8 == 0)
      else $error("dwb_post_buffer: DW must be whole bytes");

   logic [WAW-1:0] e_waddr [DEPTH];
   logic [DW-1:0]  e_data  [DEPTH];
   logic [SW-1:0]  e_strb  [DEPTH];
   logic           e_gat   [DEPTH];
   logic           e_vld   [DEPTH];
   logic [PW-1:0]  rd_ptr, wr_ptr, tail_ptr;
   logic [CW-1:0]  count;
   logic           merge_go;
   logic [DEPTH-1:0] hit_vec;

   generate
      if (MERGE_EN) begin : g_merge
         assign merge_go = merge_i;
      end else begin : g_nomerge
         assign merge_go = 1'b0;
      end
   endgenerate

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_probe
         assign hit_vec[g] = e_vld[g] && (e_waddr[g] == probe_waddr);
      end
   endgenerate

   assign probe_hit   = |hit_vec;
   assign tail_ptr    = wr_ptr - 1'b1;
   assign head_waddr  = e_waddr[rd_ptr];
   assign head_data   = e_data[rd_ptr];
   assign head_strb   = e_strb[rd_ptr];
   assign tail_waddr  = e_waddr[tail_ptr];
   assign tail_gather = e_gat[tail_ptr];
   assign count_o     = count;
   assign full_o      = count == CW'(DEPTH);
   assign empty_o     = count == '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            e_waddr[i] <= '0;
            e_data[i]  <= '0;
            e_strb[i]  <= '0;
            e_gat[i]   <= 1'b0;
            e_vld[i]   <= 1'b0;
         end
      end else begin
         if (push_i) begin
            e_waddr[wr_ptr] <= in_waddr;
            e_data[wr_ptr]  <= in_data;
            e_strb[wr_ptr]  <= in_strb;
            e_gat[wr_ptr]   <= in_gather;
            e_vld[wr_ptr]   <= 1'b1;
            wr_ptr          <= wr_ptr + 1'b1;
         end else if (merge_go) begin
            for (int b = 0; b < SW; b++) begin
               if (in_strb[b]) e_data[tail_ptr][8*b +: 8] <= in_data[8*b +: 8];
            end
            e_strb[tail_ptr] <= e_strb[tail_ptr] | in_strb;
         end
         if (pop_i) begin
            e_vld[rd_ptr] <= 1'b0;
            rd_ptr        <= rd_ptr + 1'b1;
         end
         count <= count + CW'(push_i) - CW'(pop_i);
      end
   end

   a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      full_o |-> !push_i);
   a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      empty_o |-> !pop_i);
   // R5: a merge never touches the entry that is next to leave
   a_r5_merge_not_head: assert property (@(posedge clk) disable iff (!rst_n)
      merge_go |-> (count >= CW'(2)) && !push_i);

endmodule

// File: rtl/dwb_out_stage.sv
module dwb_out_stage #(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_i,
   input  logic            write_i,
   input  logic [AW-1:0]   addr_i,
   input  logic [DW-1:0]   data_i,
   input  logic [DW/8-1:0] strb_i,
   output logic            free_o,
   output logic            dn_valid,
   input  logic            dn_ready,
   output logic            dn_write,
   output logic [AW-1:0]   dn_addr,
   output logic [DW-1:0]   dn_wdata,
   output logic [DW/8-1:0] dn_strb
);
   assign free_o = !dn_valid || dn_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dn_valid <= 1'b0;
         dn_write <= 1'b0;
         dn_addr  <= '0;
         dn_wdata <= '0;
         dn_strb  <= '0;
      end else if (free_o) begin
         dn_valid <= load_i;
         if (load_i) begin
            dn_write <= write_i;
            dn_addr  <= addr_i;
            dn_wdata <= data_i;
            dn_strb  <= strb_i;
         end
      end
   end

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid && !dn_ready |=> dn_valid && $stable(dn_addr) && $stable(dn_write)
                                && $stable(dn_wdata) && $stable(dn_strb));
   a_r9_load_when_free: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> free_o);

endmodule

// File: rtl/devmem_wbuf.sv
module devmem_wbuf #(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int BUF_DEPTH = 4,
   parameter int OUTS      = 4,
   parameter bit GATHER_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic            req_write,
   input  logic [1:0]      req_mode,
   input  logic [AW-1:0]   req_addr,
   input  logic [DW-1:0]   req_wdata,
   input  logic [DW/8-1:0] req_strb,
   output logic            wr_ack,
   output logic            wr_ack_err,
   output logic            rd_valid,
   output logic [DW-1:0]   rd_data,
   output logic            rd_err,
   output logic            dn_valid,
   input  logic            dn_ready,
   output logic            dn_write,
   output logic [AW-1:0]   dn_addr,
   output logic [DW-1:0]   dn_wdata,
   output logic [DW/8-1:0] dn_strb,
   input  logic            dn_rsp_valid,
   input  logic [DW-1:0]   dn_rsp_rdata,
   input  logic            dn_rsp_err
);
   import dwb_pkg::*;

   localparam int SW   = DW / 8;
   localparam int OFFB = $clog2(SW);
   localparam int WAW  = AW - OFFB;
   localparam int CW   = $clog2(BUF_DEPTH + 1);

   initial assert (SW >= 1 && (1 << OFFB) == SW)
      else $error("devmem_wbuf: DW/8 must be a power of two");
   initial assert (AW > OFFB)
      else $error("devmem_wbuf: AW too small");

   logic [WAW-1:0] req_waddr;
   logic           m_early, m_reorder, m_gather;
   logic           acc, direct, want_merge, push, head_go, ob_load;
   logic           ob_free, late_pend;
   logic           kinds_full, kinds_empty;
   logic [1:0]     kind_in, kind_head;
   logic           rsp_read, rsp_late;
   logic [WAW-1:0] head_waddr, tail_waddr;
   logic [DW-1:0]  head_data;
   logic [SW-1:0]  head_strb;
   logic           tail_gather, buf_full, buf_empty, buf_hit;
   logic [CW-1:0]  buf_count;
   logic           ob_write;
   logic [AW-1:0]  ob_addr;
   logic [DW-1:0]  ob_data;
   logic [SW-1:0]  ob_strb;

   assign req_waddr = req_addr[AW-1:OFFB];
   assign m_early   = mode_early(req_mode);
   assign m_reorder = mode_reorder(req_mode);
   assign m_gather  = mode_gather(req_mode) && GATHER_EN;

   always_comb begin
      if (late_pend)
         req_ready = 1'b0;
      else if (req_write && m_early)
         req_ready = !buf_full;
      else if (req_write)
         req_ready = ob_free && !kinds_full && buf_empty;
      else
         req_ready = ob_free && !kinds_full && (m_reorder ? !buf_hit : buf_empty);
   end

   assign acc        = req_valid && req_ready;
   assign direct     = acc && !(req_write && m_early);
   assign want_merge = acc && req_write && m_early && m_gather && tail_gather
                       && (buf_count >= CW'(2)) && (tail_waddr == req_waddr);
   assign push       = acc && req_write && m_early && !want_merge;
   assign head_go    = ob_free && !direct && !buf_empty && !kinds_full;
   assign ob_load    = direct || head_go;
   assign kind_in    = direct ? (req_write ? K_LATE : K_READ) : K_POSTED;

   always_comb begin
      if (direct) begin
         ob_write = req_write;
         ob_addr  = req_addr;
         ob_data  = req_wdata;
         ob_strb  = req_write ? req_strb : '0;
      end else begin
         ob_write = 1'b1;
         ob_addr  = {head_waddr, {OFFB{1'b0}}};
         ob_data  = head_data;
         ob_strb  = head_strb;
      end
   end

   dwb_post_buffer #(
      .DEPTH(BUF_DEPTH), .WAW(WAW), .DW(DW), .MERGE_EN(GATHER_EN)
   ) u_buf (
      .clk(clk), .rst_n(rst_n),
      .push_i(push), .merge_i(want_merge), .pop_i(head_go),
      .in_waddr(req_waddr), .in_data(req_wdata), .in_strb(req_strb),
      .in_gather(m_gather),
      .head_waddr(head_waddr), .head_data(head_data), .head_strb(head_strb),
      .tail_waddr(tail_waddr), .tail_gather(tail_gather),
      .count_o(buf_count), .full_o(buf_full), .empty_o(buf_empty),
      .probe_waddr(req_waddr), .probe_hit(buf_hit)
   );

   dwb_out_stage #(.AW(AW), .DW(DW)) u_out (
      .clk(clk), .rst_n(rst_n),
      .load_i(ob_load), .write_i(ob_write), .addr_i(ob_addr),
      .data_i(ob_data), .strb_i(ob_strb), .free_o(ob_free),
      .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_write(dn_write),
      .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_strb(dn_strb)
   );

   dwb_kind_fifo #(.DEPTH(OUTS), .W(2)) u_kinds (
      .clk(clk), .rst_n(rst_n),
      .push_i(ob_load), .din_i(kind_in), .pop_i(dn_rsp_valid),
      .dout_o(kind_head), .full_o(kinds_full), .empty_o(kinds_empty)
   );

   assign rsp_read = dn_rsp_valid && (kind_head == K_READ);
   assign rsp_late = dn_rsp_valid && (kind_head == K_LATE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ack     <= 1'b0;
         wr_ack_err <= 1'b0;
         rd_valid   <= 1'b0;
         rd_data    <= '0;
         rd_err     <= 1'b0;
         late_pend  <= 1'b0;
      end else begin
         wr_ack     <= push || want_merge || rsp_late;
         wr_ack_err <= rsp_late && dn_rsp_err;
         rd_valid   <= rsp_read;
         rd_err     <= rsp_read && dn_rsp_err;
         if (rsp_read) rd_data <= dn_rsp_rdata;
         if (direct && req_write) late_pend <= 1'b1;
         else if (rsp_late)       late_pend <= 1'b0;
      end
   end

   a_r3_late_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
      late_pend && !dn_rsp_valid |=> !wr_ack);
   a_r3_late_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      late_pend |-> !acc);
   a_r2_early_ack: assert property (@(posedge clk) disable iff (!rst_n)
      acc && req_write && m_early |=> wr_ack && !wr_ack_err);
   a_r6_strict_read_empty: assert property (@(posedge clk) disable iff (!rst_n)
      acc && !req_write && !m_reorder |-> buf_empty);
   a_r7_read_no_match: assert property (@(posedge clk) disable iff (!rst_n)
      acc && !req_write |-> !buf_hit);
   a_r10_read_return: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_read |=> rd_valid && rd_data == $past(dn_rsp_rdata));
   a_r10_idle_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      kinds_empty |-> !dn_rsp_valid);

endmodule

// File: tb/devmem_wbuf_bench.sv
`timescale 1ns/1ps
module devmem_wbuf_bench;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam logic [31:0] KEY = 32'h5A5A_0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [1:0]  req_mode = 2'b00;
   logic [31:0] req_addr = '0, req_wdata = '0;
   logic [3:0]  req_strb = '0;
   logic        req_ready, wr_ack, wr_ack_err, rd_valid, rd_err;
   logic [31:0] rd_data;
   logic        dn_valid, dn_write, dn_ready;
   logic [31:0] dn_addr, dn_wdata;
   logic [3:0]  dn_strb;
   logic        dn_rsp_valid = 1'b0, dn_rsp_err = 1'b0;
   logic [31:0] dn_rsp_rdata = '0;
   logic        dn_rdy_en = 1'b1;

   assign dn_ready = dn_rdy_en;

   devmem_wbuf u_devmem_wbuf (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_mode(req_mode), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_strb(req_strb), .wr_ack(wr_ack), .wr_ack_err(wr_ack_err),
      .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err),
      .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_write(dn_write),
      .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_strb(dn_strb),
      .dn_rsp_valid(dn_rsp_valid), .dn_rsp_rdata(dn_rsp_rdata),
      .dn_rsp_err(dn_rsp_err)
   );

   // downstream model: log every transaction, answer in order
   logic [31:0] log_addr [256];
   logic [31:0] log_data [256];
   logic [3:0]  log_strb [256];
   logic        log_wr   [256];
   logic [31:0] q_addr   [256];
   int n_log = 0, qh = 0, qt = 0;

   always @(posedge clk) begin
      dn_rsp_valid <= 1'b0;
      if (rst_n && dn_valid && dn_ready) begin
         log_addr[n_log] <= dn_addr;
         log_data[n_log] <= dn_wdata;
         log_strb[n_log] <= dn_strb;
         log_wr[n_log]   <= dn_write;
         n_log           <= n_log + 1;
         q_addr[qt]      <= dn_addr;
         qt              <= qt + 1;
      end
      if (qh != qt) begin
         dn_rsp_valid <= 1'b1;
         dn_rsp_rdata <= q_addr[qh] ^ KEY;
         dn_rsp_err   <= q_addr[qh][31];
         qh           <= qh + 1;
      end
   end

   int n_ack = 0, n_rd = 0;
   logic        last_ack_err = 1'b0, rd_last_err = 1'b0;
   logic [31:0] rd_last = '0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (wr_ack) begin n_ack++; last_ack_err = wr_ack_err; end
         if (rd_valid) begin n_rd++; rd_last = rd_data; rd_last_err = rd_err; end
      end
   end

   int checks = 0, fails = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic do_req(input logic wr, input logic [1:0] md, input logic [31:0] a,
                         input logic [31:0] d, input logic [3:0] s);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_mode = md;
      req_addr = a; req_wdata = d; req_strb = s;
      #1;
      while (!req_ready) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // {write, mode, addr, data, strb}
   localparam logic [70:0] VECS [8] = '{
      {1'b0, 2'b00, 32'h0000_0040, 32'h0000_0000, 4'h0},
      {1'b1, 2'b01, 32'h0000_0044, 32'h1111_2222, 4'hF},
      {1'b1, 2'b00, 32'h8000_0048, 32'h3333_4444, 4'h3},
      {1'b0, 2'b11, 32'h8000_0050, 32'h0000_0000, 4'h0},
      {1'b1, 2'b10, 32'h0000_0054, 32'h5555_6666, 4'hC},
      {1'b0, 2'b10, 32'h0000_0058, 32'h0000_0000, 4'h0},
      {1'b1, 2'b11, 32'h0000_005C, 32'h7777_8888, 4'h1},
      {1'b1, 2'b00, 32'h0000_0060, 32'h9999_AAAA, 4'hF}
   };

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int base, a0, r0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 1);
      chk(!dn_valid && !wr_ack && !rd_valid, "R1 idle outputs", 32'(dn_valid), 0);

      // table walk: one isolated transaction each
      for (int v = 0; v < 8; v++) begin
         logic        wr;
         logic [1:0]  md;
         logic [31:0] a, d;
         logic [3:0]  s;
         {wr, md, a, d, s} = VECS[v];
         base = n_log; a0 = n_ack; r0 = n_rd;
         do_req(wr, md, a, d, s);
         settle(12);
         chk(n_log == base + 1, "R4 one bus transaction", 32'(n_log - base), 1);
         chk(log_addr[base] == a && log_wr[base] == wr, "R4 bus address",
             log_addr[base], a);
         if (wr) begin
            chk(n_ack == a0 + 1, md == 2'b00 ? "R3 late ack count" : "R2 early ack count",
                32'(n_ack - a0), 1);
            chk(last_ack_err == (md == 2'b00 && a[31]), "R10 ack error flag",
                32'(last_ack_err), 32'(md == 2'b00 && a[31]));
            chk(log_data[base] == d && log_strb[base] == s, "R4 write payload",
                log_data[base], d);
         end else begin
            chk(n_rd == r0 + 1, "R10 read returned", 32'(n_rd - r0), 1);
            chk(rd_last == (a ^ KEY) && rd_last_err == a[31], "R10 read data",
                rd_last, a ^ KEY);
         end
      end

      // R2: early ack with the bus stalled
      @(negedge clk); dn_rdy_en = 1'b0;
      base = n_log; a0 = n_ack;
      do_req(1'b1, 2'b01, 32'h0000_0100, 32'hCAFE_0001, 4'hF);
      settle(3);
      chk(n_ack == a0 + 1 && n_log == base, "R2 ack before bus", 32'(n_ack - a0), 1);
      @(negedge clk); dn_rdy_en = 1'b1;
      settle(10);

      // R3 and R9: strict write holds its ack and blocks new requests
      @(negedge clk); dn_rdy_en = 1'b0;
      base = n_log; a0 = n_ack;
      do_req(1'b1, 2'b00, 32'h0000_0200, 32'hBEEF_0002, 4'hF);
      settle(8);
      chk(n_ack == a0, "R3 no ack before response", 32'(n_ack - a0), 0);
      chk(dn_valid && dn_addr == 32'h200, "R9 valid held while stalled", dn_addr, 32'h200);
      req_write = 1'b1; req_mode = 2'b01; #1;
      chk(req_ready == 1'b0, "R3 ready low while outstanding", 32'(req_ready), 0);
      @(negedge clk); dn_rdy_en = 1'b1;
      settle(10);
      chk(n_ack == a0 + 1 && n_log == base + 1, "R3 ack after response",
          32'(n_ack - a0), 1);

      // R8: capacity of queue plus issue stage
      @(negedge clk); dn_rdy_en = 1'b0;
      base = n_log;
      for (int k = 0; k < 5; k++)
         do_req(1'b1, 2'b01, 32'h0000_1000 + 32'(k * 4), 32'(k), 4'hF);
      req_write = 1'b1; req_mode = 2'b01; #1;
      chk(req_ready == 1'b0, "R8 ready low when full", 32'(req_ready), 0);
      @(negedge clk); dn_rdy_en = 1'b1;
      settle(12);
      chk(n_log == base + 5, "R8 all writes issued", 32'(n_log - base), 5);
      for (int k = 0; k < 5; k++)
         chk(log_addr[base + k] == 32'h0000_1000 + 32'(k * 4), "R8 order kept",
             log_addr[base + k], 32'h0000_1000 + 32'(k * 4));

      // R5: gathering merges into newest entry
      @(negedge clk); dn_rdy_en = 1'b0;
      base = n_log; a0 = n_ack;
      do_req(1'b1, 2'b11, 32'h0000_0100, 32'h0000_00AA, 4'h1);
      do_req(1'b1, 2'b11, 32'h0000_0200, 32'h0000_00BB, 4'h1);
      do_req(1'b1, 2'b11, 32'h0000_0300, 32'h0000_00CC, 4'h1);
      do_req(1'b1, 2'b11, 32'h0000_0301, 32'h0000_DD00, 4'h2);
      do_req(1'b1, 2'b11, 32'h0000_0302, 32'h00EE_0000, 4'h4);
      @(negedge clk); dn_rdy_en = 1'b1;
      settle(12);
      chk(n_log == base + 3, "R5 merged count", 32'(n_log - base), 3);
      chk(log_data[base + 2] == 32'h00EE_DDCC, "R5 merged data", log_data[base + 2],
          32'h00EE_DDCC);
      chk(log_strb[base + 2] == 4'h7, "R5 merged strobes", 32'(log_strb[base + 2]), 7);
      chk(n_ack == a0 + 5, "R5 every write acked", 32'(n_ack - a0), 5);

      // R4: no merge outside gathering mode
      @(negedge clk); dn_rdy_en = 1'b0;
      base = n_log;
      do_req(1'b1, 2'b10, 32'h0000_0100, 32'h1, 4'h1);
      do_req(1'b1, 2'b10, 32'h0000_0200, 32'h2, 4'h1);
      do_req(1'b1, 2'b10, 32'h0000_0300, 32'h3, 4'h1);
      do_req(1'b1, 2'b10, 32'h0000_0300, 32'h400, 4'h2);
      @(negedge clk); dn_rdy_en = 1'b1;
      settle(12);
      chk(n_log == base + 4, "R4 no merge in mode 10", 32'(n_log - base), 4);

      // R4: two reads of one address
      base = n_log; r0 = n_rd;
      do_req(1'b0, 2'b01, 32'h0000_0800, 32'h0, 4'h0);
      do_req(1'b0, 2'b01, 32'h0000_0800, 32'h0, 4'h0);
      settle(10);
      chk(n_log == base + 2 && n_rd == r0 + 2, "R4 two reads stay two",
          32'(n_log - base), 2);

      // R7: relaxed read overtakes queued writes
      @(negedge clk); dn_rdy_en = 1'b0;
      base = n_log;
      do_req(1'b1, 2'b10, 32'h0000_0400, 32'h4, 4'hF);
      do_req(1'b1, 2'b10, 32'h0000_0500, 32'h5, 4'hF);
      do_req(1'b1, 2'b10, 32'h0000_0600, 32'h6, 4'hF);
      fork
         do_req(1'b0, 2'b10, 32'h0000_0700, 32'h0, 4'h0);
         begin repeat (4) @(negedge clk); dn_rdy_en = 1'b1; end
      join
      settle(12);
      chk(log_addr[base + 1] == 32'h700 && !log_wr[base + 1], "R7 read bypasses",
          log_addr[base + 1], 32'h700);
      chk(rd_last == (32'h700 ^ KEY), "R7 read data", rd_last, 32'h700 ^ KEY);

      // R7: read matching a queued word waits for it
      @(negedge clk); dn_rdy_en = 1'b0;
      base = n_log;
      do_req(1'b1, 2'b11, 32'h0000_0400, 32'h4, 4'hF);
      do_req(1'b1, 2'b11, 32'h0000_0500, 32'h5, 4'hF);
      do_req(1'b1, 2'b11, 32'h0000_0600, 32'h6, 4'hF);
      fork
         do_req(1'b0, 2'b11, 32'h0000_0500, 32'h0, 4'h0);
         begin repeat (4) @(negedge clk); dn_rdy_en = 1'b1; end
      join
      settle(12);
      chk(log_addr[base + 2] == 32'h500 && !log_wr[base + 2], "R7 match waits",
          log_addr[base + 2], 32'h500);
      chk(log_addr[base + 3] == 32'h600, "R7 then overtakes rest", log_addr[base + 3],
          32'h600);

      // R6: strict-order read waits for all writes
      @(negedge clk); dn_rdy_en = 1'b0;
      base = n_log;
      do_req(1'b1, 2'b01, 32'h0000_0400, 32'h4, 4'hF);
      do_req(1'b1, 2'b01, 32'h0000_0500, 32'h5, 4'hF);
      do_req(1'b1, 2'b01, 32'h0000_0600, 32'h6, 4'hF);
      fork
         do_req(1'b0, 2'b01, 32'h0000_0700, 32'h0, 4'h0);
         begin repeat (4) @(negedge clk); dn_rdy_en = 1'b1; end
      join
      settle(12);
      chk(log_addr[base + 3] == 32'h700 && !log_wr[base + 3], "R6 read last",
          log_addr[base + 3], 32'h700);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule